// File: doc/BRIEF.md
# Burst Header Receiver and Request Builder

This block sits at the front of a slotted burst switch's control path. It takes one fixed-format burst header word per control slot from a single control-channel port. A header is kept only if its sync byte matches a fixed constant and its grouped parity byte is consistent with the payload. The payload of a kept header is repacked into a compact scheduling request, and that request is handed to the queue that belongs to the header's destination port, one queue per output port.

The request drops the destination field and both check bytes. In their place it carries an 8-bit arrival stamp, taken from the node's running slot counter in the slot the header arrived. Rejected headers produce no queue write. They are counted on two saturating counters, one for sync failures and one for parity failures.

Top module: `bhdr_rx`

## Requirements
- R1: The header word `hdr_word` is laid out as sync [33:26], parity [25:18] and payload [17:0]. A header is accepted only when `hdr_valid` is high, the sync byte equals parameter `SYNC` (default 8'h5A) and the parity check of R2 passes.
- R2: Parity is even and grouped. Parity bit i (hdr_word[18+i]) must equal the XOR of every payload bit j in 0..17 with j mod 8 == i. Any mismatch rejects the header.
- R3: The payload fields are destination [17:16], length [15:12], offset [11:7], channel group [6:5], ingress channel [4:1] and QoS [0]. The 24-bit request is {stamp[23:16], offset[15:11], length[10:7], channel[6:3], group[2:1], qos[0]}. It appears on every 24-bit slice of `q_data` (slice q at bits [24q+23:24q]). The slices keep the last accepted request until the next one is accepted.
- R4: Destination value d raises only `q_wr[d]`. At most one write bit is high in any cycle. The destination is not part of the request.
- R5: For an accepted header, the write bit is high for exactly the one cycle after the cycle in which `hdr_valid` was sampled high. Headers on consecutive cycles give writes on consecutive cycles. No write occurs without a header.
- R6: The stamp equals `slot_cnt` in the cycle the header was sampled. It wraps naturally from 255 to 0.
- R7: A header with a wrong sync byte causes no write. It adds one to `frame_err_cnt` and does not change `par_err_cnt`, whatever its parity.
- R8: A header with a correct sync byte and a failing parity check causes no write and adds one to `par_err_cnt`.
- R9: Both error counters stop at 2^ERR_W-1 and hold there.
- R10: While `rst_n` is low, at each clock edge `q_wr`, `q_data` and both counters clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header word present this cycle |
| hdr_word | input | 34 | Burst header word |
| slot_cnt | input | 8 | Running local slot counter |
| q_wr | output | 4 | Per-destination queue write strobe |
| q_data | output | 96 | Per-destination request data, 24 bits per queue |
| frame_err_cnt | output | ERR_W | Saturating sync failure count |
| par_err_cnt | output | ERR_W | Saturating parity failure count |

## Verification
The bench aims at headers that carry both a bad sync byte and bad parity. A design that checked parity first, or that checked both at once, would charge the parity counter as well. Single flipped parity bits and single flipped payload bits check each parity group. A wrong group map would pass a corrupted header on to a queue. Back-to-back headers and headers sent across the slot-counter wrap show any stamp taken from the wrong cycle and any strobe that is stretched or merged. Long runs of failures push both counters past their limit, where a counter that wrapped would read back as a small value.

// File: rtl/bhdr_rx.sv
module bhdr_rx #(
  parameter logic [7:0] SYNC  = 8'h5A,
  parameter int         ERR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_valid,
  input  logic [33:0]            hdr_word,
  input  logic [7:0]             slot_cnt,
  output logic [3:0]             q_wr,
  output logic [95:0]            q_data,
  output logic [ERR_W-1:0]       frame_err_cnt,
  output logic [ERR_W-1:0]       par_err_cnt
);
  localparam int DEST_W = 2;
  localparam int NDEST  = 1 << DEST_W;
  localparam int PAY_W  = 18;
  localparam int REQ_W  = 24;
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic [PAY_W-1:0] pay;
  logic [7:0]       par_calc;
  logic             frame_ok, par_ok, accept;
  logic [NDEST-1:0] wr_d;
  logic [REQ_W-1:0] req_q;

  assign pay      = hdr_word[17:0];
  assign frame_ok = hdr_word[33:26] == SYNC;
  assign par_ok   = par_calc == hdr_word[25:18];
  assign accept   = hdr_valid && frame_ok && par_ok;

  always_comb begin
    par_calc = '0;
    for (int j = 0; j < PAY_W; j++) par_calc[j % 8] = par_calc[j % 8] ^ pay[j];
  end

  always_comb begin
    wr_d = '0;
    if (accept) wr_d[pay[17:16]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_wr          <= '0;
      req_q         <= '0;
      frame_err_cnt <= '0;
      par_err_cnt   <= '0;
    end else begin
      q_wr <= wr_d;
      if (accept) req_q <= {slot_cnt, pay[11:7], pay[15:12], pay[4:1], pay[6:5], pay[0]};
      if (hdr_valid && !frame_ok && frame_err_cnt != CNT_MAX)
        frame_err_cnt <= frame_err_cnt + 1'b1;
      if (hdr_valid && frame_ok && !par_ok && par_err_cnt != CNT_MAX)
        par_err_cnt <= par_err_cnt + 1'b1;
    end
  end

  for (genvar q = 0; q < NDEST; q++) begin : g_slice
    assign q_data[q*REQ_W +: REQ_W] = req_q;
  end

  // R4
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(q_wr));
  // R5
  wr_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_wr) |-> $past(hdr_valid));
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_data) |-> (|q_wr));
  // R7
  frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_word[33:26] != SYNC) |=> (q_wr == '0));
  // R7
  fe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_err_cnt) |-> (frame_err_cnt == ERR_W'($past(frame_err_cnt) + 1'b1)));
  // R8
  pe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(par_err_cnt) |-> (par_err_cnt == ERR_W'($past(par_err_cnt) + 1'b1)));
  // R9
  fe_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err_cnt == CNT_MAX) |=> (frame_err_cnt == CNT_MAX));
  // R9
  pe_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_cnt == CNT_MAX) |=> (par_err_cnt == CNT_MAX));
endmodule

// File: tb/bhdr_rx_bench.sv
`timescale 1ns/1ps
module bhdr_rx_bench;
  localparam logic [7:0] SYNC = 8'h5A;
  localparam int ERR_W = 8;
  localparam int MAXC = (1 << ERR_W) - 1;

  logic clk = 0, rst_n = 0, hdr_valid = 0;
  logic [33:0] hdr_word = '0;
  logic [7:0] slot_cnt = '0;
  logic [3:0] q_wr;
  logic [95:0] q_data;
  logic [ERR_W-1:0] frame_err_cnt, par_err_cnt;

  int total = 0, bad = 0;
  bit started = 0, done = 0;
  logic [3:0] exp_wr = '0;
  logic [23:0] exp_data = '0;
  int exp_fe = 0, exp_pe = 0;

  bhdr_rx #(.SYNC(SYNC), .ERR_W(ERR_W)) u_bhdr_rx (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
    .slot_cnt(slot_cnt), .q_wr(q_wr), .q_data(q_data),
    .frame_err_cnt(frame_err_cnt), .par_err_cnt(par_err_cnt));

  always #2 clk = ~clk;

  always @(posedge clk) begin #1; slot_cnt = slot_cnt + 1'b1; end

  function automatic logic [33:0] mk(input logic [7:0] sy, input logic [1:0] d,
      input logic [4:0] off, input logic [3:0] len, input logic [3:0] ch,
      input logic [1:0] grp, input logic qos, input logic [7:0] pflip, input logic [17:0] dflip);
    logic [17:0] p;
    logic [7:0] par;
    p = {d, len, off, grp, ch, qos};
    par = '0;
    for (int j = 0; j < 18; j++) if (p[j]) par[j % 8] = ~par[j % 8];
    return {sy, par ^ pflip, p ^ dflip};
  endfunction

  always @(posedge clk) begin
    logic [17:0] p;
    logic [7:0] par;
    started = 1;
    if (!rst_n) begin
      exp_wr = '0; exp_data = '0; exp_fe = 0; exp_pe = 0;
    end else begin
      exp_wr = '0;
      if (hdr_valid) begin
        p = hdr_word[17:0];
        par = '0;
        for (int j = 0; j < 18; j++) if (p[j]) par[j % 8] = ~par[j % 8];
        if (hdr_word[33:26] != SYNC) begin
          if (exp_fe < MAXC) exp_fe++;
        end else if (par != hdr_word[25:18]) begin
          if (exp_pe < MAXC) exp_pe++;
        end else begin
          exp_wr[p[17:16]] = 1'b1;
          exp_data = {slot_cnt, p[11:7], p[15:12], p[4:1], p[6:5], p[0]};
        end
      end
    end
  end

  always @(negedge clk) if (started && !done) begin
    total++;
    if (q_wr !== exp_wr) begin
      bad++; $display("FAIL R1/R4/R5 q_wr actual=%b expected=%b", q_wr, exp_wr);
    end
    for (int q = 0; q < 4; q++) begin
      total++;
      if (q_data[q*24 +: 24] !== exp_data) begin
        bad++; $display("FAIL R3/R6 q_data[%0d] actual=%h expected=%h", q, q_data[q*24 +: 24], exp_data);
      end
    end
    total++;
    if (frame_err_cnt !== ERR_W'(exp_fe)) begin
      bad++; $display("FAIL R7/R9 frame_err_cnt actual=%0d expected=%0d", frame_err_cnt, exp_fe);
    end
    total++;
    if (par_err_cnt !== ERR_W'(exp_pe)) begin
      bad++; $display("FAIL R2/R8/R9 par_err_cnt actual=%0d expected=%0d", par_err_cnt, exp_pe);
    end
  end

  task automatic drive(input logic v, input logic [33:0] h);
    @(posedge clk); #1; hdr_valid = v; hdr_word = h;
  endtask

  task automatic good(input logic [1:0] d);
    drive(1, mk(SYNC, d, 5'($urandom), 4'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), 8'h0, 18'h0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    // R10 reset state
    if (q_wr !== 0 || q_data !== 0 || frame_err_cnt !== 0 || par_err_cnt !== 0) begin
      bad++; $display("FAIL R10 reset actual=%b/%h/%0d/%0d expected=0", q_wr, q_data, frame_err_cnt, par_err_cnt);
    end
    @(posedge clk); #1; rst_n = 1;
    for (int d = 0; d < 4; d++) good(2'(d));
    drive(0, '0);
    for (int d = 3; d >= 0; d--) begin good(2'(d)); drive(0, '0); end
    for (int i = 0; i < 18; i++)
      drive(1, mk(SYNC, 2'(i), 5'(i), 4'(i), 4'(i), 2'(i), 1'(i), 8'h0, 18'(1) << i));
    for (int i = 0; i < 8; i++)
      drive(1, mk(SYNC, 2'(i), 5'(i), 4'(i), 4'(i), 2'(i), 1'(i), 8'(1) << i, 18'h0));
    drive(1, mk(8'hA5, 2'd1, 5'd3, 4'd2, 4'd1, 2'd0, 1'b1, 8'h10, 18'h0));
    drive(1, mk(8'h5B, 2'd2, 5'd3, 4'd2, 4'd1, 2'd0, 1'b1, 8'h00, 18'h4));
    drive(0, '0);
    while (slot_cnt != 8'hFD) drive(0, '0);
    good(2'd0); good(2'd1); good(2'd2);
    drive(0, '0);
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) drive(0, '0);
      else if (r < 7) good(2'($urandom));
      else if (r < 8) drive(1, mk(8'($urandom) | 8'h01 ^ SYNC, 2'($urandom), 5'($urandom), 4'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), 18'h0));
      else drive(1, mk(SYNC, 2'($urandom), 5'($urandom), 4'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), 8'(1) << $urandom_range(0, 7), 18'h0));
    end
    for (int i = 0; i < 300; i++) drive(1, mk(8'h00, 2'd3, 5'd1, 4'd1, 4'd1, 2'd1, 1'b0, 8'h0, 18'h0));
    good(2'd2);
    for (int i = 0; i < 300; i++) drive(1, mk(SYNC, 2'd1, 5'd9, 4'd1, 4'd1, 2'd1, 1'b0, 8'h80, 18'h0));
    good(2'd3);
    drive(0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule